// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block runs the signals at a crossing where a main road meets a side road, with one vehicle sensor on the side road. A clock divider produces a one-clock enable pulse once per second, and every duration in the controller is counted in those pulses. The main road keeps its green for a minimum of 25 seconds and keeps it beyond that for as long as the side road is empty. A car waiting on the side road then starts the change, through a 4-second yellow, to side-road green. Side-road green lasts for as long as a car is detected, but never longer than 25 seconds. A 4-second yellow on the side road then hands the junction back to the main road.

The phase is held in a 2-bit Gray-coded register, which is also brought out for observation. Each road has three lamp lines. The sensor input is taken through a two-flop synchronizer before any decision uses it. The divider ratio and both durations are parameters, so a simulation can run with only a few clocks per second.

Top module: `tlc_junction`

## Requirements
- R1: A synchronous reset puts the controller in main-green (phase code 00) and clears the divider and the phase timer. The first counted second ends CLKS_PER_TICK clocks after reset is released.
- R2: The one-second enable is a single-clock pulse once every CLKS_PER_TICK clocks. All durations are counted in these pulses, starting from a timer that is zero on the first cycle of each phase.
- R3: Main-green lasts until at least GREEN_TICKS seconds have been counted. After that it continues for as long as the synchronized sensor shows no car.
- R4: Once GREEN_TICKS seconds have elapsed in main-green, a synchronized car indication moves the phase to main-yellow (code 01) on the next clock.
- R5: Each yellow phase (main-yellow 01, side-yellow 10) lasts exactly AMBER_TICKS counted seconds and then advances.
- R6: In side-green (code 11), a synchronized indication of no car moves the phase to side-yellow on the next clock.
- R7: Side-green lasts no more than GREEN_TICKS counted seconds, even while a car is still detected.
- R8: The phase order is 00, 01, 11, 10 and then 00 again. Each transition changes exactly one bit of the phase code.
- R9: Each road lights exactly one lamp. The road that is neither green nor yellow shows red, and the two roads are never green at the same time.
- R10: A change on the sensor input affects the phase decision after two clocks of synchronization. A change applied before clock edge E can therefore first change the phase at edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| car_detect | input | 1 | Side-road vehicle sensor, asynchronous |
| main_red | output | 1 | Main road red lamp |
| main_yel | output | 1 | Main road yellow lamp |
| main_grn | output | 1 | Main road green lamp |
| side_red | output | 1 | Side road red lamp |
| side_yel | output | 1 | Side road yellow lamp |
| side_grn | output | 1 | Side road green lamp |
| phase_code | output | 2 | Gray-coded current phase |

## Verification
The bench targets several corner cases:
- A car that arrives before the main-green minimum has run out. A design that acted on it would cut main-green short.
- A main-green that is held well past the minimum by an empty side road. If the timer wrapped instead of saturating, the handover would be delayed, or a false one would fire.
- A sensor drop in the middle of side-green. This must end the phase exactly three edges after the input changes. A missing or extra synchronizer stage shifts that edge.
- A car that stays present for the whole of side-green. A design without the cap never leaves side-green.

Exact transition edges counted from reset expose an off-by-one in the divider or in the timer comparisons. A mid-run reset checks that the divider and the timer really clear.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'b00,
    PH_MAIN_WARN = 2'b01,
    PH_SIDE_GO   = 2'b11,
    PH_SIDE_WARN = 2'b10
  } phase_t;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamp_t;

  // Successor in the fixed rotation; one bit flips per step.
  function automatic phase_t phase_after(input phase_t p);
    unique case (p)
      PH_MAIN_GO:   phase_after = PH_MAIN_WARN;
      PH_MAIN_WARN: phase_after = PH_SIDE_GO;
      PH_SIDE_GO:   phase_after = PH_SIDE_WARN;
      default:      phase_after = PH_MAIN_GO;
    endcase
  endfunction

  // Lamp set for one road: is_side selects which road is asked about.
  function automatic lamp_t lamps_for(input phase_t p, input logic is_side);
    lamp_t l;
    l = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    if (!is_side) begin
      if (p == PH_MAIN_GO)   l = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
      if (p == PH_MAIN_WARN) l = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
    end else begin
      if (p == PH_SIDE_GO)   l = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
      if (p == PH_SIDE_WARN) l = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
    end
    return l;
  endfunction

endpackage

// File: rtl/tlc_tick_gen.sv
module tlc_tick_gen #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tlc_sync.sv
module tlc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tlc_phase_timer.sv
module tlc_phase_timer #(
  parameter int unsigned CAP = 25
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       tick,
  output logic [$clog2(CAP+1)-1:0]   elapsed
);
  localparam int unsigned W = $clog2(CAP + 1);
  localparam logic [W-1:0] TOP = W'(CAP);

  always_ff @(posedge clk) begin
    if (rst || clear)               elapsed <= '0;
    else if (tick && elapsed != TOP) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/tlc_junction.sv
module tlc_junction
  import tlc_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 50_000_000,
  parameter int unsigned GREEN_TICKS   = 25,
  parameter int unsigned AMBER_TICKS   = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_detect,
  output logic       main_red,
  output logic       main_yel,
  output logic       main_grn,
  output logic       side_red,
  output logic       side_yel,
  output logic       side_grn,
  output logic [1:0] phase_code
);
  localparam int unsigned CAP = (GREEN_TICKS > AMBER_TICKS) ? GREEN_TICKS : AMBER_TICKS;
  localparam int unsigned TW  = $clog2(CAP + 1);
  localparam logic [TW-1:0] GREEN_LIM = TW'(GREEN_TICKS);
  localparam logic [TW-1:0] AMBER_LIM = TW'(AMBER_TICKS);

  phase_t          phase_q, phase_d;
  logic            sec_tick;
  logic            car_sync;
  logic [TW-1:0]   elapsed;
  logic            green_done, amber_done, phase_change;
  lamp_t           main_l, side_l;

  tlc_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .tick(sec_tick)
  );

  tlc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(car_detect), .dout(car_sync)
  );

  tlc_phase_timer #(.CAP(CAP)) u_timer (
    .clk(clk), .rst(rst), .clear(phase_change), .tick(sec_tick), .elapsed(elapsed)
  );

  assign green_done   = (elapsed >= GREEN_LIM);
  assign amber_done   = (elapsed >= AMBER_LIM);
  assign phase_change = (phase_d != phase_q);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_MAIN_GO:   if (green_done && car_sync)    phase_d = phase_after(phase_q);
      PH_MAIN_WARN: if (amber_done)                phase_d = phase_after(phase_q);
      PH_SIDE_GO:   if (green_done || !car_sync)   phase_d = phase_after(phase_q);
      default:      if (amber_done)                phase_d = phase_after(phase_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_MAIN_GO;
    else     phase_q <= phase_d;
  end

  assign main_l = lamps_for(phase_q, 1'b0);
  assign side_l = lamps_for(phase_q, 1'b1);

  assign main_red   = main_l.red;
  assign main_yel   = main_l.yel;
  assign main_grn   = main_l.grn;
  assign side_red   = side_l.red;
  assign side_yel   = side_l.yel;
  assign side_grn   = side_l.grn;
  assign phase_code = phase_q;
endmodule

// File: rtl/tlc_junction_chk.sv
module tlc_junction_chk
  import tlc_pkg::*;
#(
  parameter int unsigned DIV   = 50_000_000,
  parameter int unsigned GREEN = 25,
  parameter int unsigned AMBER = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       car_sync,
  input logic [1:0] phase,
  input logic [1:0] phase_nx,
  input logic       main_red,
  input logic       main_yel,
  input logic       main_grn,
  input logic       side_red,
  input logic       side_yel,
  input logic       side_grn
);
  localparam int unsigned GREEN_MIN = (GREEN - 1) * DIV + 1;
  localparam int unsigned GREEN_MAX = GREEN * DIV;
  localparam int unsigned AMBER_MIN = (AMBER - 1) * DIV + 1;
  localparam int unsigned AMBER_MAX = AMBER * DIV;

  int unsigned dwell;

  always_ff @(posedge clk) begin
    if (rst)                      dwell <= 0;
    else if (phase_nx != phase)   dwell <= 0;
    else if (dwell < GREEN_MAX + AMBER_MAX) dwell <= dwell + 1;
  end

  // R1
  reset_phase_chk: assert property (@(posedge clk) $past(rst) |-> phase == 2'b00);

  // R8
  gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_nx != phase) |-> $countones(phase_nx ^ phase) == 1);

  // R8
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_nx != phase) |-> phase_nx == phase_after(phase_t'(phase)));

  // R9
  lamp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({main_red, main_yel, main_grn}) && $onehot({side_red, side_yel, side_grn}));

  // R9
  no_dual_green_chk: assert property (@(posedge clk) disable iff (rst)
    !(main_grn && side_grn));

  // R9
  cross_red_chk: assert property (@(posedge clk) disable iff (rst)
    (!main_red |-> side_red) and (!side_red |-> main_red));

  // R3
  main_min_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && phase_nx != 2'b00) |-> dwell >= GREEN_MIN);

  // R4
  main_needs_car_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && phase_nx != 2'b00) |-> car_sync);

  // R5
  amber_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase[0] != phase[1] && phase_nx != phase) |-> (dwell >= AMBER_MIN && dwell <= AMBER_MAX));

  // R6
  side_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b11 && !car_sync) |-> phase_nx == 2'b10);

  // R7
  side_max_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b11) |-> dwell <= GREEN_MAX);
endmodule

bind tlc_junction tlc_junction_chk #(
  .DIV(CLKS_PER_TICK), .GREEN(GREEN_TICKS), .AMBER(AMBER_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .car_sync(car_sync),
  .phase(phase_q), .phase_nx(phase_d),
  .main_red(main_red), .main_yel(main_yel), .main_grn(main_grn),
  .side_red(side_red), .side_yel(side_yel), .side_grn(side_grn)
);

// File: tb/tlc_junction_bench.sv
module tlc_junction_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int GREEN = 25;
  localparam int AMBER = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_detect = 1'b1;
  logic main_red, main_yel, main_grn, side_red, side_yel, side_grn;
  logic [1:0] phase_code;

  int total = 0;
  int bad = 0;
  int ecnt = 0;
  bit cmp_on = 0;

  // behavioural reference state
  int m_phase = 0;
  int m_el = 0;
  int m_dc = 0;
  bit m_q[$] = '{1'b0, 1'b0};

  tlc_junction #(
    .CLKS_PER_TICK(DIV), .GREEN_TICKS(GREEN), .AMBER_TICKS(AMBER), .SYNC_STAGES(2)
  ) u_tlc_junction (
    .clk(clk), .rst(rst), .car_detect(car_detect),
    .main_red(main_red), .main_yel(main_yel), .main_grn(main_grn),
    .side_red(side_red), .side_yel(side_yel), .side_grn(side_grn),
    .phase_code(phase_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int lamps_exp(input int ph);
    // order: main r,y,g then side r,y,g
    case (ph)
      0: return 6'b001_100;
      1: return 6'b010_100;
      3: return 6'b100_001;
      default: return 6'b100_010;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) ecnt <= 0; else ecnt <= ecnt + 1;
  end

  // reference model, stepped on each clock
  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_el = 0; m_dc = 0; m_q = '{1'b0, 1'b0};
    end else begin
      bit car;
      bit tk;
      int nx;
      car = m_q[0];
      tk = (m_dc == DIV - 1);
      nx = m_phase;
      if (m_phase == 0 && m_el >= GREEN && car) nx = 1;
      else if (m_phase == 1 && m_el >= AMBER) nx = 3;
      else if (m_phase == 3 && (m_el >= GREEN || !car)) nx = 2;
      else if (m_phase == 2 && m_el >= AMBER) nx = 0;
      if (nx != m_phase) m_el = 0;
      else if (tk && m_el < GREEN) m_el++;
      m_dc = tk ? 0 : m_dc + 1;
      void'(m_q.pop_front());
      m_q.push_back(car_detect);
      m_phase = nx;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 phase vs model", int'(phase_code), m_phase);
      chk("R9 lamps vs model",
          int'({main_red, main_yel, main_grn, side_red, side_yel, side_grn}),
          lamps_exp(m_phase));
    end
  end

  task automatic run_until_change(output int at_edge);
    logic [1:0] prev;
    prev = phase_code;
    at_edge = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (phase_code != prev) begin
        at_edge = ecnt;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e1, e2, e3, e4, e0, ex;
    bit [7:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset phase", int'(phase_code), 0);
    chk("R1 reset lamps",
        int'({main_red, main_yel, main_grn, side_red, side_yel, side_grn}), lamps_exp(0));
    cmp_on = 1;
    rst = 1'b0;

    // car present throughout: exact edges from reset release
    run_until_change(e1);
    chk("R2 R3 R4 main green ends at edge", e1, GREEN * DIV + 1);
    chk("R4 main yellow entered", int'(phase_code), 1);
    run_until_change(e2);
    chk("R5 main yellow length", e2 - e1, AMBER * DIV);
    chk("R8 side green code", int'(phase_code), 3);
    run_until_change(e3);
    chk("R7 side green capped", e3 - e2, GREEN * DIV);
    run_until_change(e4);
    chk("R5 side yellow length", e4 - e3, AMBER * DIV);
    chk("R8 back to main green", int'(phase_code), 0);

    // empty side road: main green held well past the minimum
    car_detect = 1'b0;
    repeat (300) @(negedge clk);
    chk("R3 main green extended", int'(phase_code), 0);
    car_detect = 1'b1;
    e0 = ecnt;
    run_until_change(ex);
    chk("R4 R10 car latency to yellow", ex - e0, 3);

    // side green ending early when the car leaves
    run_until_change(ex);
    chk("R8 side green reached", int'(phase_code), 3);
    repeat (10) @(negedge clk);
    car_detect = 1'b0;
    e0 = ecnt;
    run_until_change(ex);
    chk("R6 R10 side green early end", ex - e0, 3);
    chk("R6 side yellow code", int'(phase_code), 2);

    // short car pulse during the main-green minimum must not start a change
    run_until_change(ex);
    car_detect = 1'b1;
    repeat (2) @(negedge clk);
    car_detect = 1'b0;
    repeat (40) @(negedge clk);
    chk("R3 early car ignored", int'(phase_code), 0);

    // irregular sensor traffic, model compared every clock
    lfsr = 8'h5a;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i % 5 == 0) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        car_detect = lfsr[0] | lfsr[1];
      end
    end

    // mid-run reset clears everything
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid-run reset phase", int'(phase_code), 0);
    rst = 1'b0;
    car_detect = 1'b1;
    run_until_change(e1);
    chk("R1 R2 timing restarts after reset", e1, GREEN * DIV + 1);
    repeat (20) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule